// File: doc/BRIEF.md
# Dual-Channel Simultaneous Converter Readout with Correction

This block collects results from a two-channel successive-approximation converter that samples a voltage and a current at the same instant. The converter exposes two serial data lines that share one serial clock driven by this block. Both results therefore shift in side by side in the same clock periods. A conversion-start pulse arms the block. An event-driven state machine then waits for the converter's ready indication and shifts in 20 bits per lane. It corrects each lane for offset and gain, and presents the pair with a one-cycle strobe.

Each lane is corrected independently. The block subtracts a signed offset from the signed raw code and multiplies the difference by an unsigned gain with 17 fraction bits. It keeps three extra fraction bits and clamps the result to a signed 24-bit range. A start that arrives while a read is in progress is dropped and reported on an overrun pulse.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, sclk, out_valid and overrun are 0, and out_volt and out_curr are 0.
- R2: sclk stays low outside the shifting phase. Each read produces exactly 20 rising edges of sclk and ends with sclk low.
- R3: On each rising sclk edge the block takes one bit from each of sdo_a and sdo_b, most significant bit first. The 20-bit codes are signed two's complement.
- R4: Each output is floor(((raw - offset) * gain) / 2^14). Here raw and offset are signed 20-bit values and gain is unsigned 18-bit with 17 fraction bits, so 0x20000 means 1.0.
- R5: A corrected value above 2^23-1 is output as 0x7FFFFF. A value below -2^23 is output as 0x800000.
- R6: out_valid is high for exactly one cycle per read. out_volt carries lane A (sdo_a) and out_curr carries lane B (sdo_b). Both outputs hold their values until the next strobe.
- R7: A conv_start that arrives while the block is not idle pulses overrun for one cycle in the next clock. That start produces no additional read and no additional strobe.
- R8: After conv_start, the block drives no sclk edge until it samples adc_rdy high.
- R9: While shifting, sclk toggles every clk_div+1 system clock cycles.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | One-cycle pulse at the shared conversion start |
| adc_rdy | input | 1 | Converter indicates results are ready to shift |
| sdo_a | input | 1 | Serial data, voltage lane |
| sdo_b | input | 1 | Serial data, current lane |
| clk_div | input | 8 | sclk half period minus one, in system clocks |
| offset_a | input | 20 | Signed offset, voltage lane |
| offset_b | input | 20 | Signed offset, current lane |
| gain_a | input | 18 | Unsigned gain with 17 fraction bits, voltage lane |
| gain_b | input | 18 | Unsigned gain with 17 fraction bits, current lane |
| sclk | output | 1 | Shared serial clock to both data lines |
| out_valid | output | 1 | One-cycle strobe for a corrected pair |
| out_volt | output | 24 | Corrected voltage sample, signed |
| out_curr | output | 24 | Corrected current sample, signed |
| overrun | output | 1 | One-cycle pulse when a start arrives during a read |

## Verification
A wrong bit counter shows at the ports within a single read. The sclk rising-edge count per strobe differs from 20, and the sample comes out shifted by a power of two. A swapped or mis-sampled lane shows as a wrong value at the first strobe. The test patterns are asymmetric so that a lane swap, a bit-order error or an off-by-one capture changes the value. A state machine that leaves the idle state on a dropped start shows as an extra strobe or as sclk activity after the expected result. The overrun and ready-gating paths are observed within a few cycles of their stimulus.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        RD_IDLE    = 3'd0,
        RD_WAIT    = 3'd1,
        RD_SHIFT   = 3'd2,
        RD_CORRECT = 3'd3,
        RD_OUTPUT  = 3'd4
    } rd_state_e;
endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lane_corrector.sv
module lane_corrector #(
    parameter int SW = 20,
    parameter int GW = 18,
    parameter int OW = 24
) (
    input  logic signed [SW-1:0] raw,
    input  logic signed [SW-1:0] off,
    input  logic        [GW-1:0] gain,
    output logic signed [OW-1:0] res
);
    localparam int PW    = SW + GW + 2;
    localparam int SHIFT = (GW - 1) - (OW - SW - 1);
    localparam logic signed [PW-1:0] MAXV = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [SW:0]   diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        diff   = $signed({raw[SW-1], raw}) - $signed({off[SW-1], off});
        prod   = diff * $signed({1'b0, gain});
        scaled = prod >>> SHIFT;
        if (scaled > MAXV)      res = MAXV[OW-1:0];
        else if (scaled < MINV) res = MINV[OW-1:0];
        else                    res = scaled[OW-1:0];
    end
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int SW    = 20,
    parameter int GW    = 18,
    parameter int OW    = 24,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             adc_rdy,
    input  logic             sdo_a,
    input  logic             sdo_b,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [SW-1:0]    offset_a,
    input  logic [SW-1:0]    offset_b,
    input  logic [GW-1:0]    gain_a,
    input  logic [GW-1:0]    gain_b,
    output logic             sclk,
    output logic             out_valid,
    output logic [OW-1:0]    out_volt,
    output logic [OW-1:0]    out_curr,
    output logic             overrun
);
    localparam int NL = 2;
    localparam int BW = $clog2(SW + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(SW);

    typedef struct packed {
        rd_state_e             st;
        logic [BW-1:0]         bit_cnt;
        logic                  sclk;
        logic [NL-1:0][SW-1:0] sh;
        logic [NL-1:0][OW-1:0] res;
        logic                  valid;
        logic                  ovr;
    } rd_regs_t;

    rd_regs_t q, d;

    logic                  tick;
    logic [NL-1:0]         sdo_vec;
    logic [NL-1:0][SW-1:0] off_vec;
    logic [NL-1:0][GW-1:0] gain_vec;
    logic [NL-1:0][OW-1:0] corr;
    rd_state_e             st_w;
    logic [BW-1:0]         bit_cnt_w;

    assign sdo_vec  = {sdo_b, sdo_a};
    assign off_vec  = {offset_b, offset_a};
    assign gain_vec = {gain_b, gain_a};

    sclk_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st == RD_SHIFT),
        .div  (clk_div),
        .tick (tick)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lane
        lane_corrector #(.SW(SW), .GW(GW), .OW(OW)) corr_i (
            .raw (q.sh[g]),
            .off (off_vec[g]),
            .gain(gain_vec[g]),
            .res (corr[g])
        );
    end

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ovr   = conv_start && (q.st != RD_IDLE);
        case (q.st)
            RD_IDLE: begin
                if (conv_start) begin
                    d.st      = RD_WAIT;
                    d.bit_cnt = '0;
                end
            end
            RD_WAIT: begin
                if (adc_rdy) d.st = RD_SHIFT;
            end
            RD_SHIFT: begin
                if (tick) begin
                    d.sclk = ~q.sclk;
                    if (!q.sclk) begin
                        for (int l = 0; l < NL; l++)
                            d.sh[l] = {q.sh[l][SW-2:0], sdo_vec[l]};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (q.bit_cnt == LAST_BIT) begin
                        d.st = RD_CORRECT;
                    end
                end
            end
            RD_CORRECT: begin
                d.res   = corr;
                d.valid = 1'b1;
                d.st    = RD_OUTPUT;
            end
            RD_OUTPUT: d.st = RD_IDLE;
            default:   d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= RD_IDLE;
            q.bit_cnt <= '0;
            q.sclk    <= 1'b0;
            q.sh      <= '0;
            q.res     <= '0;
            q.valid   <= 1'b0;
            q.ovr     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk      = q.sclk;
    assign out_valid = q.valid;
    assign out_volt  = q.res[0];
    assign out_curr  = q.res[1];
    assign overrun   = q.ovr;
    assign st_w      = q.st;
    assign bit_cnt_w = q.bit_cnt;
endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk
    import adc_rd_pkg::*;
#(
    parameter int OW = 24,
    parameter int BW = 5,
    parameter int SW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_start,
    input logic          sclk,
    input logic          out_valid,
    input logic [OW-1:0] out_volt,
    input logic [OW-1:0] out_curr,
    input logic          overrun,
    input rd_state_e     st,
    input logic [BW-1:0] bit_cnt
);
    p_sclk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RD_SHIFT) |-> !sclk);

    p_bit_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BW'(SW));

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_volt) && $stable(out_curr)));

    p_busy_start_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && st != RD_IDLE) |=> overrun);

    p_strobe_after_correct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(st) == RD_CORRECT);
endmodule

bind dual_adc_reader dual_adc_reader_chk #(.OW(OW), .BW(BW), .SW(SW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .sclk      (sclk),
    .out_valid (out_valid),
    .out_volt  (out_volt),
    .out_curr  (out_curr),
    .overrun   (overrun),
    .st        (st_w),
    .bit_cnt   (bit_cnt_w)
);

// File: tb/dual_adc_reader_tb_top.sv
module dual_adc_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        adc_rdy = 1'b0;
    logic        sdo_a = 1'b0;
    logic        sdo_b = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic [19:0] offset_a = '0, offset_b = '0;
    logic [17:0] gain_a = '0, gain_b = '0;
    logic        sclk, out_valid, overrun;
    logic [23:0] out_volt, out_curr;

    always #4 clk = ~clk;

    dual_adc_reader dut_i (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .adc_rdy(adc_rdy),
        .sdo_a(sdo_a), .sdo_b(sdo_b), .clk_div(clk_div),
        .offset_a(offset_a), .offset_b(offset_b), .gain_a(gain_a), .gain_b(gain_b),
        .sclk(sclk), .out_valid(out_valid), .out_volt(out_volt),
        .out_curr(out_curr), .overrun(overrun)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [23:0] v;
        logic [23:0] i;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // converter model: next bit presented after each falling sclk edge
    logic [19:0] mod_a, mod_b;
    int          mod_idx = 0;
    always @(negedge sclk) begin
        if (mod_idx > 0) begin
            mod_idx = mod_idx - 1;
            sdo_a   = mod_a[mod_idx];
            sdo_b   = mod_b[mod_idx];
        end
    end

    function automatic logic [23:0] model_corr(logic [19:0] raw, logic [19:0] off, logic [17:0] g);
        longint dv, p;
        dv = longint'($signed(raw)) - longint'($signed(off));
        p  = (dv * longint'({46'b0, g})) >>> 14;
        if (p > 64'sd8388607)  p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return p[23:0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor
    int  rises = 0;
    int  since_tog = 0;
    bit  tog_seen = 0;
    bit  prev_sclk = 0, prev_valid = 0;
    int  ovr_cnt = 0;
    int  results = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            since_tog++;
            if (sclk != prev_sclk) begin
                if (tog_seen)
                    check(since_tog == int'(clk_div) + 1, "R9", "sclk half period", since_tog, int'(clk_div) + 1);
                tog_seen  = 1;
                since_tog = 0;
                if (sclk) rises++;
            end
            if (overrun) ovr_cnt++;
            if (prev_valid && out_valid) check(0, "R6", "strobe longer than one cycle", 1, 0);
            if (out_valid && !prev_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_volt == e.v, e.tag, "out_volt (lane A)", out_volt, e.v);
                    check(out_curr == e.i, e.tag, "out_curr (lane B)", out_curr, e.i);
                    check(rises == 20, "R2", "sclk rises per read", rises, 20);
                    check(sclk == 1'b0, "R2", "sclk low at strobe", sclk, 0);
                end
                rises    = 0;
                tog_seen = 0;
                results++;
            end
            prev_sclk  = sclk;
            prev_valid = out_valid;
        end
    end

    task automatic do_read(logic [19:0] ra, logic [19:0] rb, logic [19:0] oa, logic [19:0] ob,
                           logic [17:0] ga, logic [17:0] gb, logic [7:0] dv,
                           int rdy_wait, bit inject, string tag);
        exp_t e;
        int   base, ovr0;
        @(negedge clk);
        clk_div  = dv;
        offset_a = oa; offset_b = ob; gain_a = ga; gain_b = gb;
        mod_a = ra; mod_b = rb; mod_idx = 19;
        sdo_a = ra[19]; sdo_b = rb[19];
        e.v = model_corr(ra, oa, ga);
        e.i = model_corr(rb, ob, gb);
        e.tag = tag;
        exp_q.push_back(e);
        base = results;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        repeat (rdy_wait) @(negedge clk);
        // R8: no serial activity while the ready indication is low
        check(rises == 0 && sclk == 1'b0, "R8", "sclk before ready", rises, 0);
        adc_rdy = 1'b1;
        @(negedge clk);
        adc_rdy = 1'b0;
        if (inject) begin
            repeat (2 * (int'(dv) + 1) * 3) @(negedge clk);
            ovr0 = ovr_cnt;
            conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
            check(overrun == 1'b1, "R7", "overrun pulse", overrun, 1);
            @(negedge clk);
            check(overrun == 1'b0 && ovr_cnt == ovr0 + 1, "R7", "overrun single cycle", ovr_cnt - ovr0, 1);
        end
        while (results == base) @(negedge clk);
        repeat (4) @(negedge clk);
        // a dropped start must not launch a second read
        if (inject) begin
            adc_rdy = 1'b1;
            repeat (30) @(negedge clk);
            adc_rdy = 1'b0;
            check(results == base + 1 && sclk == 1'b0 && rises == 0, "R7", "no read from dropped start",
                  results - base, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk == 0 && out_valid == 0 && overrun == 0, "R1", "control outputs after reset",
              {sclk, out_valid, overrun}, 0);
        check(out_volt == 0 && out_curr == 0, "R1", "data outputs after reset", out_volt, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // unity gain, zero offset: value is raw scaled by 8
        do_read(20'h12345, 20'hFABCD, 20'h0, 20'h0, 18'h20000, 18'h20000, 8'd0, 3, 0, "R3");
        // offsets and fractional gains, negative results, slower sclk
        do_read(20'h0F0F0, 20'h80123, 20'h00100, 20'hFFF00, 18'h10000, 18'h18000, 8'd2, 10, 0, "R4");
        do_read(20'hC3A51, 20'h05A5A, 20'h7FFFF, 20'h80000, 18'h0ABCD, 18'h1FFFF, 8'd1, 1, 0, "R4");
        // clamping both directions
        do_read(20'h7FFFF, 20'h80000, 20'h80000, 20'h7FFFF, 18'h3FFFF, 18'h3FFFF, 8'd0, 2, 0, "R5");
        do_read(20'h80000, 20'h7FFFF, 20'h7FFFF, 20'h80000, 18'h30000, 18'h2C000, 8'd3, 2, 0, "R5");
        // zero gain, long ready wait
        do_read(20'h55555, 20'hAAAAA, 20'h00011, 20'h00022, 18'h00000, 18'h00000, 8'd5, 40, 0, "R4");
        // start while busy
        do_read(20'h3C3C3, 20'hC3C3C, 20'h00000, 20'h00000, 18'h20000, 18'h08000, 8'd1, 2, 1, "R6");
        check(exp_q.size() == 0, "R6", "pending results", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule